// File: doc/BRIEF.md
# Edge-Latching Interrupt Aggregator with Set/Clear Registers

This block collects thirty-two edge-type interrupt sources and folds them into one request line for a parent interrupt controller. Every rising edge on a source input is caught in a pending bit. The pending bit holds until software acknowledges it. A per-source mask bit decides whether that pending bit can drive the request line. Software can also raise pending bits itself, which lets a handler be tested or a source replayed without toggling any hardware line.

Software reaches the state through a small word-addressed register bus. Pending bits and mask bits are never written directly. Each has a write-one-to-set port and a write-one-to-clear port, so any single bit can be changed in one write without a read-modify-write. A read-only view of each returns the current contents. The request line is asserted whenever at least one pending bit is unmasked.

Top module: `irq_set_clr_agg`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1 (the mask view at byte offset 0x0C reads 0xFFFFFFFF), the pending view at 0x00 reads 0 and `irqOut` is low.
- R2: A 0-to-1 change on `srcIn[i]` sets pending bit i, and bit i can be read at offset 0x00 one clock later. The bit stays set after the source drops.
- R3: Writing offset 0x08 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Writing offset 0x04 sets each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Writing offset 0x10 sets each mask bit written as 1, and writing offset 0x14 clears each mask bit written as 1. Bits written as 0 are unchanged. Offset 0x0C reads back the mask, where 1 means the source is masked.
- R6: `irqOut` is high exactly when the bitwise AND of the pending bits and the inverted mask bits is nonzero.
- R7: Setting a mask bit leaves the matching pending bit set and still visible at offset 0x00.
- R8: If a source's rising edge and a clear-write naming the same bit arrive in the same cycle, the bit stays pending.
- R9: Offsets 0x04, 0x08, 0x10, 0x14 and any unmapped offset read as 0. Writes to 0x00 and 0x0C change nothing.
- R10: A source held high after its pending bit has been cleared does not set the bit again until it drops and rises once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Interrupt source lines, one per bit |
| busAddr | input | 5 | Byte offset of the register being accessed |
| busWrite | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Aggregated request to the parent controller |

## Verification
A source edge or a bus write is registered at the next rising clock edge. The new pending or mask value, and `irqOut` derived from it, are therefore due one clock after the stimulus is applied. Reads are combinational from the registers, so a read value is due in the same cycle the address is presented. The bench drives every input on a falling edge, lets exactly one rising edge pass, and then samples on the following falling edge just after it sets the read address. The same-cycle edge-versus-clear case applies both stimuli on the same falling edge, so they meet at one rising edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Byte offsets of the register window
  localparam int OFF_PEND     = 'h00;
  localparam int OFF_PEND_SET = 'h04;
  localparam int OFF_PEND_CLR = 'h08;
  localparam int OFF_MASK     = 'h0C;
  localparam int OFF_MASK_SET = 'h10;
  localparam int OFF_MASK_CLR = 'h14;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic setMask;
    logic clrMask;
    logic rdPend;
    logic rdMask;
  } ctrlStb_t;

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineIn,
  output logic [WIDTH-1:0] riseOut
);

  logic [WIDTH-1:0] linePrev;

  always_ff @(posedge clk) begin
    if (!rstN) linePrev <= '0;
    else       linePrev <= lineIn;
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : gRise
      assign riseOut[gi] = lineIn[gi] & ~linePrev[gi];
    end
  endgenerate

  // A held-high line yields a single rise
  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (riseOut != '0) |=> ((riseOut & $past(riseOut)) == '0)); // R10

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output ctrlStb_t          stb
);

  localparam logic [ADDR_W-1:0] A_PEND     = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_PEND_SET = ADDR_W'(OFF_PEND_SET);
  localparam logic [ADDR_W-1:0] A_PEND_CLR = ADDR_W'(OFF_PEND_CLR);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(OFF_MASK_CLR);

  always_comb begin
    stb = '0;
    unique case (busAddr)
      A_PEND:     stb.rdPend  = 1'b1;
      A_MASK:     stb.rdMask  = 1'b1;
      A_PEND_SET: stb.setPend = busWrite;
      A_PEND_CLR: stb.clrPend = busWrite;
      A_MASK_SET: stb.setMask = busWrite;
      A_MASK_CLR: stb.clrMask = busWrite;
      default:    stb = '0;
    endcase
  end

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (busAddr == A_PEND || busAddr == A_MASK))
      |-> !(stb.setPend || stb.clrPend || stb.setMask || stb.clrMask)); // R9

  AST_WO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_PEND_SET || busAddr == A_PEND_CLR ||
     busAddr == A_MASK_SET || busAddr == A_MASK_CLR)
      |-> !(stb.rdPend || stb.rdMask)); // R9

endmodule

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] riseIn,
  output logic [WIDTH-1:0] rdata,
  output logic             irqOut
);

  logic [WIDTH-1:0] pendQ, maskQ;
  logic [WIDTH-1:0] pendSetVec, pendClrVec, maskSetVec, maskClrVec;

  assign pendSetVec = stb.setPend ? wdata : '0;
  assign pendClrVec = stb.clrPend ? wdata : '0;
  assign maskSetVec = stb.setMask ? wdata : '0;
  assign maskClrVec = stb.clrMask ? wdata : '0;

  // A fresh edge outranks an acknowledge of the same bit
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~pendClrVec) | pendSetVec | riseIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '1;
    else       maskQ <= (maskQ & ~maskClrVec) | maskSetVec;
  end

  always_comb begin
    if (stb.rdPend)      rdata = pendQ;
    else if (stb.rdMask) rdata = maskQ;
    else                 rdata = '0;
  end

  assign irqOut = |(pendQ & ~maskQ);

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (riseIn != '0) |=> ((pendQ & $past(riseIn)) == $past(riseIn))); // R2

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clrPend |=> ((pendQ & $past(pendQ)) == $past(pendQ))); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrPend |=> ((pendQ & $past(wdata & ~riseIn)) == '0)); // R3

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.setPend |=> ((pendQ & $past(wdata)) == $past(wdata))); // R4

  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrPend && ((riseIn & wdata) != '0))
      |=> ((pendQ & $past(riseIn & wdata)) == $past(riseIn & wdata))); // R8

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> ((maskQ & $past(wdata)) == $past(wdata))); // R5

  AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> ((maskQ & $past(wdata)) == '0)); // R5

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut); // R6

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(stb.setPend || stb.clrMask || (riseIn != '0))); // R6

endmodule

// File: rtl/irq_set_clr_agg.sv
module irq_set_clr_agg
  import irqagg_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [NSRC-1:0]   busWdata,
  output logic [NSRC-1:0]   busRdata,
  output logic              irqOut
);

  ctrlStb_t        stb;
  logic [NSRC-1:0] riseVec;

  irqagg_edge #(.WIDTH(NSRC)) uEdge (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (srcIn),
    .riseOut (riseVec)
  );

  irqagg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .stb      (stb)
  );

  irqagg_dp #(.WIDTH(NSRC)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .riseIn (riseVec),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/sim_irq_set_clr_agg.sv
module sim_irq_set_clr_agg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_set_clr_agg u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Write lands at the next rising edge; returns on the following falling edge
  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tReset();
    rdChk("R1 pend", 5'h00, 32'h0);
    rdChk("R1 mask", 5'h0C, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tEdge();
    @(negedge clk); srcIn[5] = 1'b1;
    @(negedge clk); srcIn[5] = 1'b0;
    rdChk("R2 latched", 5'h00, 32'h0000_0020);
    @(negedge clk);
    rdChk("R2 held after drop", 5'h00, 32'h0000_0020);
    chk("R6 masked no irq", {31'b0, irqOut}, 32'h0);
    busWr(5'h08, 32'h0000_0020);
    rdChk("R3 ack", 5'h00, 32'h0);
    // level held high
    @(negedge clk); srcIn[6] = 1'b1;
    @(negedge clk);
    rdChk("R10 first rise", 5'h00, 32'h0000_0040);
    busWr(5'h08, 32'h0000_0040);
    @(negedge clk); @(negedge clk);
    rdChk("R10 no re-latch", 5'h00, 32'h0);
    srcIn[6] = 1'b0;
    @(negedge clk); srcIn[6] = 1'b1;
    @(negedge clk); srcIn[6] = 1'b0;
    rdChk("R10 new rise", 5'h00, 32'h0000_0040);
    busWr(5'h08, 32'hFFFF_FFFF);
  endtask

  task automatic tSwSetClr();
    busWr(5'h04, 32'hA5A5_0000);
    rdChk("R4 set", 5'h00, 32'hA5A5_0000);
    busWr(5'h04, 32'h0000_00FF);
    rdChk("R4 zeros keep", 5'h00, 32'hA5A5_00FF);
    busWr(5'h08, 32'h0505_0F0F);
    rdChk("R3 partial clear", 5'h00, 32'hA0A0_00F0);
    busWr(5'h08, 32'hFFFF_FFFF);
    rdChk("R3 clear all", 5'h00, 32'h0);
  endtask

  task automatic tMask();
    busWr(5'h14, 32'h0000_FFFF);
    rdChk("R5 mask clr", 5'h0C, 32'hFFFF_0000);
    busWr(5'h10, 32'h0000_0101);
    rdChk("R5 mask set", 5'h0C, 32'hFFFF_0101);
    busWr(5'h14, 32'h0001_0000);
    rdChk("R5 mask clr2", 5'h0C, 32'hFFFE_0101);
  endtask

  task automatic tIrq();
    busWr(5'h04, 32'h0000_0100);
    chk("R6 masked pend", {31'b0, irqOut}, 32'h0);
    busWr(5'h04, 32'h0000_0002);
    chk("R6 unmasked pend", {31'b0, irqOut}, 32'h1);
    busWr(5'h08, 32'h0000_0002);
    chk("R6 after ack", {31'b0, irqOut}, 32'h0);
    busWr(5'h04, 32'h0001_0000);
    chk("R6 high bit", {31'b0, irqOut}, 32'h1);
    busWr(5'h08, 32'hFFFF_FFFF);
    chk("R6 all clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tMaskKeeps();
    busWr(5'h04, 32'h0000_0004);
    chk("R7 unmasked irq", {31'b0, irqOut}, 32'h1);
    busWr(5'h10, 32'h0000_0004);
    chk("R7 masked irq", {31'b0, irqOut}, 32'h0);
    rdChk("R7 still pending", 5'h00, 32'h0000_0004);
    busWr(5'h08, 32'h0000_0004);
  endtask

  task automatic tEdgeWins();
    busWr(5'h04, 32'h0000_0018);
    @(negedge clk);
    srcIn[3] = 1'b1;
    busAddr = 5'h08; busWdata = 32'h0000_0018; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0; srcIn[3] = 1'b0;
    rdChk("R8 edge beats clear", 5'h00, 32'h0000_0008);
    busWr(5'h08, 32'hFFFF_FFFF);
  endtask

  task automatic tReadOnly();
    busWr(5'h00, 32'hFFFF_FFFF);
    rdChk("R9 pend write ignored", 5'h00, 32'h0);
    busWr(5'h0C, 32'h0000_0000);
    rdChk("R9 mask write ignored", 5'h0C, 32'hFFFE_0105);
    busWr(5'h04, 32'h1234_5678);
    rdChk("R9 set reads 0", 5'h04, 32'h0);
    rdChk("R9 clr reads 0", 5'h08, 32'h0);
    rdChk("R9 mset reads 0", 5'h10, 32'h0);
    rdChk("R9 mclr reads 0", 5'h14, 32'h0);
    rdChk("R9 unmapped reads 0", 5'h18, 32'h0);
    rdChk("R9 pend intact", 5'h00, 32'h1234_5678);
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEdge();
    tSwSetClr();
    tMask();
    tIrq();
    tMaskKeeps();
    tEdgeWins();
    tReadOnly();
    finished = 1'b1;
    finishSim();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishSim();
    end
  end

endmodule